// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector

This block compares two pulse trains sampled on the system clock: a reference train and a divided oscillator train. A rising edge on one input opens a correction pulse that lasts until the matching rising edge arrives on the other input. The width of that pulse in clock cycles is therefore the gap between the two edges. When the reference edge comes first, the pulse asks the loop to raise the oscillator frequency. When the oscillator edge comes first, it asks the loop to lower it. The loop assumes that the oscillator frequency goes up as its control voltage goes up.

The result is presented in two forms. The first is a single three-state pump line, given as a drive level with an output enable: it is high for "raise" and low for "lower", and it floats when no pulse is open. The second is a pair of open-drain style device enables: an upper device that pulls the control node high and a lower device that pulls it low. Each form has its own enable bit, so a board can use the pump line with a passive filter or the device pair with an active filter. A sleep input and a hold-clear input each turn every output off at once, and each discards any pulse in progress.

Top module: `pfd_tristate_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls with both pulse inputs low, all four outputs are 0.
- R2: With no pulse open, a rising edge on `ref_pulse` alone opens a raise pulse. From the cycle of that edge, `int_oe`=1, `int_drive`=1, `ext_up_on`=1 and `ext_dn_on`=0.
- R3: With no pulse open, a rising edge on `vco_pulse` alone opens a lower pulse. From the cycle of that edge, `int_oe`=1, `int_drive`=0, `ext_dn_on`=1 and `ext_up_on`=0.
- R4: An open raise pulse closes in the cycle of the next `vco_pulse` rising edge. An open lower pulse closes in the cycle of the next `ref_pulse` rising edge. The pulse width in cycles equals the edge separation.
- R5: Rising edges on both inputs in the same cycle, with no pulse open, open nothing: the pump line floats and both devices stay off.
- R6: A further rising edge on the input that opened the pulse, while that pulse is still open, changes nothing.
- R7: When `int_en` is 0, `int_oe` and `int_drive` are 0 in that same cycle. The device enables are not affected.
- R8: When `ext_en` is 0, `ext_up_on` and `ext_dn_on` are 0 in that same cycle. The pump line is not affected.
- R9: When `sleep` or `hold_clear` is 1, all outputs are 0 in that same cycle. Any open pulse is discarded, and edges seen in that cycle open nothing.
- R10: Only a low-to-high change of an input counts as an edge. An input held high does not retrigger.
- R11: `int_drive` is 0 whenever `int_oe` is 0, and the two device enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Divided reference pulse train |
| vco_pulse | input | 1 | Divided oscillator pulse train |
| int_en | input | 1 | Enables the three-state pump line |
| ext_en | input | 1 | Enables the upper/lower device pair |
| sleep | input | 1 | Power-save: forces all outputs off |
| hold_clear | input | 1 | Hold-in-clear: forces all outputs off and drops state |
| int_drive | output | 1 | Pump line level (1 raise, 0 lower) |
| int_oe | output | 1 | Pump line enable (0 = high impedance) |
| ext_up_on | output | 1 | Upper (pull-high) device on |
| ext_dn_on | output | 1 | Lower (pull-low) device on |

## Verification
Two functions can land in the same cycle. One is the opening of a pulse by one input and the closing of a pulse by the other. The other is an edge arriving in the very cycle that sleep or hold-clear is asserted. The bench provokes the first by giving both inputs a rising edge in one cycle, both from the idle state and while a pulse is open. It provokes the second by raising sleep or hold-clear together with an edge. A behavioural model decides which of the two events wins in each case, and the outputs are compared against that model on every cycle. A long stretch of sparse random edges with changing enables follows, to hit further coincidences.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int PD_NUM_IN  = 2;
    localparam int PD_IDX_REF = 0;
    localparam int PD_IDX_VCO = 1;

    typedef enum logic [1:0] {
        PD_IDLE    = 2'b00,
        PD_PUMP_UP = 2'b01,
        PD_PUMP_DN = 2'b10
    } pd_state_e;

    typedef struct packed {
        logic int_drive;
        logic int_oe;
        logic ext_up_on;
        logic ext_dn_on;
    } pump_drive_t;

    function automatic pump_drive_t pd_map_drive(
        input pd_state_e st,
        input logic      int_en,
        input logic      ext_en,
        input logic      off
    );
        pump_drive_t d;
        logic        act_up;
        logic        act_dn;
        act_up      = (st == PD_PUMP_UP) && !off;
        act_dn      = (st == PD_PUMP_DN) && !off;
        d.int_oe    = int_en && (act_up || act_dn);
        d.int_drive = int_en && act_up;
        d.ext_up_on = ext_en && act_up;
        d.ext_dn_on = ext_en && act_dn;
        return d;
    endfunction

endpackage

// File: rtl/pfd_rise_detect.sv
module pfd_rise_detect #(
    parameter int NUM_IN = pfd_pkg::PD_NUM_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] sig_in,
    output logic [NUM_IN-1:0] rise
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~prev_q;
    end

endmodule

// File: rtl/pfd_pump_fsm.sv
module pfd_pump_fsm
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      off,
    input  logic      ref_rise,
    input  logic      vco_rise,
    output pd_state_e state
);

    pd_state_e nxt;

    always_comb begin
        nxt = state;
        if (off) begin
            nxt = PD_IDLE;
        end else begin
            case (state)
                PD_IDLE: begin
                    if (ref_rise && !vco_rise)      nxt = PD_PUMP_UP;
                    else if (vco_rise && !ref_rise) nxt = PD_PUMP_DN;
                end
                PD_PUMP_UP: if (vco_rise) nxt = PD_IDLE;
                PD_PUMP_DN: if (ref_rise) nxt = PD_IDLE;
                default:    nxt = PD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PD_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/pfd_drive_map.sv
module pfd_drive_map
    import pfd_pkg::*;
(
    input  pd_state_e   state,
    input  logic        int_en,
    input  logic        ext_en,
    input  logic        off,
    output pump_drive_t drv
);

    assign drv = pd_map_drive(state, int_en, ext_en, off);

endmodule

// File: rtl/pfd_tristate_top.sv
module pfd_tristate_top
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic vco_pulse,
    input  logic int_en,
    input  logic ext_en,
    input  logic sleep,
    input  logic hold_clear,
    output logic int_drive,
    output logic int_oe,
    output logic ext_up_on,
    output logic ext_dn_on
);

    logic [PD_NUM_IN-1:0] pulses;
    logic [PD_NUM_IN-1:0] rises;
    logic                 off;
    pd_state_e            state;
    pump_drive_t          drv;

    assign off                = sleep | hold_clear;
    assign pulses[PD_IDX_REF] = ref_pulse;
    assign pulses[PD_IDX_VCO] = vco_pulse;

    pfd_rise_detect #(.NUM_IN(PD_NUM_IN)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .sig_in (pulses),
        .rise   (rises)
    );

    pfd_pump_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .off      (off),
        .ref_rise (rises[PD_IDX_REF]),
        .vco_rise (rises[PD_IDX_VCO]),
        .state    (state)
    );

    pfd_drive_map u_map (
        .state  (state),
        .int_en (int_en),
        .ext_en (ext_en),
        .off    (off),
        .drv    (drv)
    );

    assign int_drive = drv.int_drive;
    assign int_oe    = drv.int_oe;
    assign ext_up_on = drv.ext_up_on;
    assign ext_dn_on = drv.ext_dn_on;

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
    input logic clk,
    input logic rst,
    input logic ref_pulse,
    input logic vco_pulse,
    input logic int_en,
    input logic ext_en,
    input logic sleep,
    input logic hold_clear,
    input logic int_drive,
    input logic int_oe,
    input logic ext_up_on,
    input logic ext_dn_on
);

    logic ref_d, vco_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d <= 1'b0;
            vco_d <= 1'b0;
        end else begin
            ref_d <= ref_pulse;
            vco_d <= vco_pulse;
        end
    end

    logic ref_e, vco_e, off_c, idle_seen;
    assign ref_e     = ref_pulse & ~ref_d;
    assign vco_e     = vco_pulse & ~vco_d;
    assign off_c     = sleep | hold_clear;
    assign idle_seen = ext_en && !off_c && !ext_up_on && !ext_dn_on;

    AST_EXT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ext_up_on && ext_dn_on)); // R11
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !int_oe |-> !int_drive); // R11
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        off_c |-> !(int_oe || ext_up_on || ext_dn_on)); // R9
    AST_UP_START: assert property (@(posedge clk) disable iff (rst)
        (idle_seen && ref_e && !vco_e) |=> (!ext_en || off_c || ext_up_on)); // R2
    AST_DN_START: assert property (@(posedge clk) disable iff (rst)
        (idle_seen && vco_e && !ref_e) |=> (!ext_en || off_c || ext_dn_on)); // R3
    AST_TIE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (idle_seen && ref_e && vco_e) |=> (!ext_up_on && !ext_dn_on)); // R5
    AST_HOLD_UP: assert property (@(posedge clk) disable iff (rst)
        (ext_en && !off_c && ext_up_on && !vco_e) |=> (!ext_en || off_c || ext_up_on)); // R6

endmodule

bind pfd_tristate_top pfd_tristate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_pulse  (ref_pulse),
    .vco_pulse  (vco_pulse),
    .int_en     (int_en),
    .ext_en     (ext_en),
    .sleep      (sleep),
    .hold_clear (hold_clear),
    .int_drive  (int_drive),
    .int_oe     (int_oe),
    .ext_up_on  (ext_up_on),
    .ext_dn_on  (ext_dn_on)
);

// File: tb/tb_pfd_tristate_top.sv
`timescale 1ns/1ps
module tb_pfd_tristate_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0, vco_pulse = 1'b0;
    logic int_en = 1'b1, ext_en = 1'b1;
    logic sleep = 1'b0, hold_clear = 1'b0;
    logic int_drive, int_oe, ext_up_on, ext_dn_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state: 0 idle, 1 raise open, 2 lower open
    int m_state = 0;
    bit m_ref_prev = 1'b0, m_vco_prev = 1'b0;

    always #2 clk = ~clk;

    pfd_tristate_top dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .int_en(int_en), .ext_en(ext_en), .sleep(sleep), .hold_clear(hold_clear),
        .int_drive(int_drive), .int_oe(int_oe), .ext_up_on(ext_up_on), .ext_dn_on(ext_dn_on)
    );

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {drive,oe,up,dn} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit er, ev, off;
        er  = ref_pulse && !m_ref_prev;
        ev  = vco_pulse && !m_vco_prev;
        off = sleep || hold_clear;
        if (off) m_state = 0;
        else if (m_state == 0) begin
            if (er && !ev) m_state = 1;
            else if (ev && !er) m_state = 2;
        end else if (m_state == 1) begin
            if (ev) m_state = 0;
        end else begin
            if (er) m_state = 0;
        end
        m_ref_prev = ref_pulse;
        m_vco_prev = vco_pulse;
    endtask

    function automatic logic [3:0] model_out();
        bit off, oe, drv, up, dn;
        off = sleep || hold_clear;
        oe  = int_en && !off && (m_state != 0);
        drv = oe && (m_state == 1);
        up  = ext_en && !off && (m_state == 1);
        dn  = ext_en && !off && (m_state == 2);
        return {drv, oe, up, dn};
    endfunction

    // called just after a negedge: drive inputs, cross one posedge, compare at the next negedge
    task automatic step(input bit r, input bit v, input bit ie, input bit ee,
                        input bit sl, input bit hc, input string req);
        ref_pulse = r; vco_pulse = v; int_en = ie; ext_en = ee;
        sleep = sl; hold_clear = hc;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check4(req, {int_drive, int_oe, ext_up_on, ext_dn_on}, model_out());
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check4("R1", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        #1 rst = 1'b0;
        step(0,0,1,1,0,0,"R1");
        check4("R1", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);

        // raise pulse, held level, re-edge, closing edge
        step(1,0,1,1,0,0,"R2");
        check4("R2", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b1110);
        step(1,0,1,1,0,0,"R10");
        step(0,0,1,1,0,0,"R4");
        step(1,0,1,1,0,0,"R6");
        check4("R6", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b1110);
        step(0,1,1,1,0,0,"R4");
        check4("R4", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,1,1,1,0,0,"R10");
        check4("R10", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,0,1,1,0,0,"R4");

        // lower pulse of width 3 cycles
        step(0,1,1,1,0,0,"R3");
        check4("R3", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0101);
        step(0,0,1,1,0,0,"R4");
        step(0,0,1,1,0,0,"R4");
        step(1,0,1,1,0,0,"R4");
        check4("R4", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,0,1,1,0,0,"R4");

        // coincident edges from idle, then while a pulse is open
        step(1,1,1,1,0,0,"R5");
        check4("R5", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,0,1,1,0,0,"R5");
        step(0,1,1,1,0,0,"R3");
        step(0,0,1,1,0,0,"R3");
        step(1,1,1,1,0,0,"R4");
        step(0,0,1,1,0,0,"R4");

        // enable bits
        step(1,0,0,1,0,0,"R7");
        check4("R7", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0010);
        step(0,0,1,0,0,0,"R8");
        check4("R8", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b1100);
        step(0,1,1,1,0,0,"R4");
        step(0,0,1,1,0,0,"R4");
        step(0,1,1,0,0,0,"R8");
        check4("R8", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0100);
        step(0,0,0,1,0,0,"R11");
        check4("R11", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0001);

        // sleep and hold-clear drop the open pulse
        step(0,0,1,1,1,0,"R9");
        check4("R9", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,0,1,1,0,0,"R9");
        check4("R9", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(1,0,1,1,0,1,"R9");
        step(0,0,1,1,0,0,"R9");
        check4("R9", {int_drive, int_oe, ext_up_on, ext_dn_on}, 4'b0000);
        step(0,1,1,1,1,0,"R9");
        step(0,0,1,1,0,0,"R9");

        // sparse random edges with changing controls
        for (int i = 0; i < 3000; i++) begin
            bit r, v, ie, ee, sl, hc;
            r  = ($urandom_range(0, 5) == 0);
            v  = ($urandom_range(0, 5) == 0);
            ie = ($urandom_range(0, 7) != 0);
            ee = ($urandom_range(0, 7) != 0);
            sl = ($urandom_range(0, 40) == 0);
            hc = ($urandom_range(0, 60) == 0);
            step(r, v, ie, ee, sl, hc, "R4");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule